// File: doc/BRIEF.md
# Converter Result Holding Register with Tear-Free Byte Reads

This block holds the latest 10-bit result from a data converter and presents it to an 8-bit register bus as a pair of byte registers: a low byte at offset 0x78 and a high byte at offset 0x79. A configuration input selects how the 10 bits are packed into the 16-bit pair. With right alignment, software reads the full value as an ordinary 16-bit number. With left alignment, the high byte alone is an 8-bit approximation of the result.

Software reads the pair one byte at a time, so a new result could otherwise land between the two reads and mix bytes from two different conversions. To prevent this, a low-byte read locks the pair. Any completion that arrives while the pair is locked is parked in a shadow register, and only the newest parked result is kept. The following high-byte read unlocks the pair and moves the parked result into view. A high-byte read made without a preceding low-byte read leaves no lock behind, so an 8-bit reader that uses left alignment never blocks updates.

Top module: `adc_result_latch`

## Requirements
- R1: After reset, reads of both 0x78 and 0x79 return 0x00, and the pair is unlocked, so the first completion becomes visible.
- R2: With `align_left`=0, a read of 0x78 returns result bits 7:0, and a read of 0x79 returns {6'b0, result bits 9:8}.
- R3: With `align_left`=1, a read of 0x79 returns result bits 9:2, and a read of 0x78 returns {result bits 1:0, 6'b0}.
- R4: A `conv_done` pulse while the pair is unlocked, and with no low-byte read in the same cycle, makes `conv_value` readable from the cycle after the pulse.
- R5: After a low-byte read, later `conv_done` pulses leave both visible bytes unchanged until a high-byte read.
- R6: On the high-byte read that ends a lock, the newest result that completed during the lock is visible from the next cycle. A completion in the same cycle as that read counts as the newest. If nothing completed during the lock, the value stays unchanged.
- R7: A high-byte read while unlocked has no side effect: the next completion still updates the visible pair at once.
- R8: `align_left` is applied at read time, so changing it repacks the stored result with no new conversion.
- R9: `bus_rdata` is 0x00 whenever `bus_rd` is low or the address is neither 0x78 nor 0x79.
- R10: A completion in the same cycle as a low-byte read does not change the visible pair. It is parked and appears after the next high-byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe, one per cycle of access |
| bus_rdata | output | 8 | Read data, valid in the cycle of the strobe |
| conv_done | input | 1 | Converter completion pulse |
| conv_value | input | 10 | Converter result, valid with `conv_done` |
| align_left | input | 1 | 0 = right-aligned packing, 1 = left-aligned packing |

## Verification
A lock flag that is stuck or wrongly set shows up at the ports on the first completion after a low-byte read. Either the next high-byte read returns a byte from the newer result (a torn pair), or a later read keeps returning an old value after the pair should have been released. A lost or stale shadow value is seen one cycle after the unlocking high-byte read, when the low byte does not match the newest parked result. Packing faults are seen in the same cycle as the read strobe, because read data is combinational from the stored result.

// File: rtl/adcres_pkg.sv
package adcres_pkg;
  parameter int RES_W  = 10;
  parameter int BYTE_W = 8;
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int PAD_W  = PAIR_W - RES_W;

  typedef logic [RES_W-1:0]  res_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/adcres_rst_sync.sv
module adcres_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/adcres_decode.sv
module adcres_decode
  import adcres_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h78
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  output logic              lo_rd,
  output logic              hi_rd,
  output rd_sel_e           sel
);
  localparam logic [ADDR_W-1:0] HI_ADDR = LO_ADDR + 1'b1;

  always_comb begin
    lo_rd = bus_rd && (bus_addr == LO_ADDR);
    hi_rd = bus_rd && (bus_addr == HI_ADDR);
    if (lo_rd)      sel = SEL_LO;
    else if (hi_rd) sel = SEL_HI;
    else            sel = SEL_NONE;
  end
endmodule

// File: rtl/adcres_store.sv
module adcres_store
  import adcres_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic conv_done,
  input  res_t conv_value,
  input  logic lo_rd,
  input  logic hi_rd,
  output res_t vis_q,
  output res_t shadow_q,
  output logic lock_q,
  output logic pend_q
);
  res_t vis_n, shadow_n;
  logic lock_n, pend_n;
  logic vis_en, shadow_en, lock_en, pend_en;

  always_comb begin
    vis_n     = vis_q;
    shadow_n  = shadow_q;
    lock_n    = lock_q;
    pend_n    = pend_q;
    vis_en    = 1'b0;
    shadow_en = 1'b0;
    lock_en   = 1'b0;
    pend_en   = 1'b0;
    if (lock_q) begin
      if (hi_rd) begin
        lock_n  = 1'b0; lock_en = 1'b1;
        pend_n  = 1'b0; pend_en = 1'b1;
        if (conv_done) begin
          vis_n = conv_value; vis_en = 1'b1;
        end else if (pend_q) begin
          vis_n = shadow_q;   vis_en = 1'b1;
        end
      end else if (conv_done) begin
        shadow_n = conv_value; shadow_en = 1'b1;
        pend_n   = 1'b1;       pend_en   = 1'b1;
      end
    end else begin
      if (lo_rd) begin
        lock_n = 1'b1; lock_en = 1'b1;
        if (conv_done) begin
          shadow_n = conv_value; shadow_en = 1'b1;
          pend_n   = 1'b1;       pend_en   = 1'b1;
        end
      end else if (conv_done) begin
        vis_n = conv_value; vis_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_q    <= '0;
      shadow_q <= '0;
      lock_q   <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (vis_en)    vis_q    <= vis_n;
      if (shadow_en) shadow_q <= shadow_n;
      if (lock_en)   lock_q   <= lock_n;
      if (pend_en)   pend_q   <= pend_n;
    end
  end
endmodule

// File: rtl/adcres_pack.sv
module adcres_pack
  import adcres_pkg::*;
(
  input  res_t  vis,
  input  logic  align_left,
  output byte_t lo_byte,
  output byte_t hi_byte
);
  logic [PAIR_W-1:0] pair;

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        if (align_left) pair = {vis, {PAD_W{1'b0}}};
        else            pair = {{PAD_W{1'b0}}, vis};
      end
    end else begin : g_full
      always_comb pair = PAIR_W'(vis);
    end
  endgenerate

  assign lo_byte = pair[BYTE_W-1:0];
  assign hi_byte = pair[PAIR_W-1:BYTE_W];
endmodule

// File: rtl/adcres_rdmux.sv
module adcres_rdmux
  import adcres_pkg::*;
(
  input  rd_sel_e sel,
  input  byte_t   lo_byte,
  input  byte_t   hi_byte,
  output byte_t   rdata
);
  always_comb begin
    unique case (sel)
      SEL_LO:  rdata = lo_byte;
      SEL_HI:  rdata = hi_byte;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch
  import adcres_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_value,
  input  logic              align_left
);
  logic    rst_sync_n;
  logic    lo_rd, hi_rd;
  rd_sel_e sel;
  res_t    vis_q, shadow_q;
  logic    lock_q, pend_q;
  byte_t   lo_byte, hi_byte;

  adcres_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  adcres_decode #(.ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR)) u_dec (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .lo_rd    (lo_rd),
    .hi_rd    (hi_rd),
    .sel      (sel)
  );

  adcres_store u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .conv_done  (conv_done),
    .conv_value (conv_value),
    .lo_rd      (lo_rd),
    .hi_rd      (hi_rd),
    .vis_q      (vis_q),
    .shadow_q   (shadow_q),
    .lock_q     (lock_q),
    .pend_q     (pend_q)
  );

  adcres_pack u_pack (
    .vis        (vis_q),
    .align_left (align_left),
    .lo_byte    (lo_byte),
    .hi_byte    (hi_byte)
  );

  adcres_rdmux u_mux (
    .sel     (sel),
    .lo_byte (lo_byte),
    .hi_byte (hi_byte),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/adcres_checker.sv
module adcres_checker
  import adcres_pkg::*;
#(
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h78
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              conv_done,
  input logic [RES_W-1:0]  conv_value,
  input logic              align_left,
  input logic [RES_W-1:0]  vis_q,
  input logic [RES_W-1:0]  shadow_q,
  input logic              lock_q,
  input logic              pend_q
);
  localparam logic [ADDR_W-1:0] HI_ADDR = LO_ADDR + 1'b1;
  logic lo_a, hi_a;
  assign lo_a = bus_rd && (bus_addr == LO_ADDR);
  assign hi_a = bus_rd && (bus_addr == HI_ADDR);

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_a && !hi_a) |-> (bus_rdata == '0));

  // R2
  right_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_a && !align_left) |-> (bus_rdata == vis_q[BYTE_W-1:0]));

  // R3
  left_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_a && align_left) |-> (bus_rdata == vis_q[RES_W-1 -: BYTE_W]));

  // R4
  free_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && !lo_a && conv_done) |=> (vis_q == $past(conv_value)));

  // R5
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !hi_a) |=> $stable(vis_q));

  // R6
  release_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && hi_a && pend_q && !conv_done) |=> (vis_q == $past(shadow_q)));

  // R7
  hi_only_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && hi_a) |=> !lock_q);

  // R10
  same_cycle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && lo_a && conv_done) |=> ($stable(vis_q) && pend_q));
endmodule

bind adc_result_latch adcres_checker #(.ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .conv_done  (conv_done),
  .conv_value (conv_value),
  .align_left (align_left),
  .vis_q      (vis_q),
  .shadow_q   (shadow_q),
  .lock_q     (lock_q),
  .pend_q     (pend_q)
);

// File: tb/sim_adc_result_latch.sv
module sim_adc_result_latch;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_rd;
  logic [7:0] bus_rdata;
  logic       conv_done;
  logic [9:0] conv_value;
  logic       align_left;

  int checks = 0;
  int errors = 0;

  logic [9:0] m_vis, m_shadow;
  logic       m_lock, m_pend;

  always #5 clk = ~clk;

  adc_result_latch u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .conv_done  (conv_done),
    .conv_value (conv_value),
    .align_left (align_left)
  );

  function automatic logic [7:0] exp_byte(input logic rd, input logic [7:0] a,
                                          input logic [9:0] v, input logic al);
    if (!rd) return 8'h00;
    if (a == 8'h78) return al ? {v[1:0], 6'b0} : v[7:0];
    if (a == 8'h79) return al ? v[9:2] : {6'b0, v[9:8]};
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // one bus/converter cycle; read data checked mid-cycle, model advanced at the edge
  task automatic step(input logic rd, input logic [7:0] a, input logic d,
                      input logic [9:0] v, input logic al, input string tag);
    string t;
    @(negedge clk);
    bus_rd = rd; bus_addr = a; conv_done = d; conv_value = v; align_left = al;
    #1;
    t = tag;
    if (t == "") begin
      if (!rd || (a != 8'h78 && a != 8'h79)) t = "R9";
      else t = al ? "R3" : "R2";
    end
    check(t, bus_rdata, exp_byte(rd, a, m_vis, al));
    @(posedge clk);
    if (m_lock) begin
      if (rd && a == 8'h79) begin
        m_lock = 1'b0;
        if (d) m_vis = v; else if (m_pend) m_vis = m_shadow;
        m_pend = 1'b0;
      end else if (d) begin
        m_shadow = v; m_pend = 1'b1;
      end
    end else if (rd && a == 8'h78) begin
      m_lock = 1'b1;
      if (d) begin m_shadow = v; m_pend = 1'b1; end
    end else if (d) m_vis = v;
  endtask

  task automatic idle(input logic al); step(0, 8'h00, 0, 10'h0, al, ""); endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_vis = '0; m_shadow = '0; m_lock = 0; m_pend = 0;
    rst_n = 1'b0; bus_rd = 0; bus_addr = 0; conv_done = 0; conv_value = 0; align_left = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    step(1, 8'h78, 0, 0, 0, "R1");
    step(1, 8'h79, 0, 0, 0, "R1");
    // R1/R7: high read left no lock, first completion visible
    step(0, 0, 1, 10'h2A5, 0, "R4");
    step(1, 8'h78, 0, 0, 0, "R4");          // expect A5, locks
    step(1, 8'h79, 0, 0, 0, "R2");          // expect 02, unlocks
    // R3 and R8: repack without conversion
    step(1, 8'h79, 0, 0, 1, "R8");          // expect A9
    step(1, 8'h79, 0, 0, 1, "R3");
    // R7: hi-only reads, then a completion must show at once
    step(0, 0, 1, 10'h0FF, 1, "R7");
    step(1, 8'h79, 0, 0, 1, "R7");          // expect 3F
    step(1, 8'h78, 0, 0, 1, "R7");          // expect C0, locks
    // R5: completions during lock ignored
    step(0, 0, 1, 10'h111, 1, "R5");
    step(0, 0, 1, 10'h3C3, 1, "R5");
    step(1, 8'h78, 0, 0, 1, "R5");          // still C0
    step(1, 8'h79, 0, 0, 1, "R5");          // still 3F, releases
    // R6: newest parked value visible
    step(1, 8'h79, 0, 0, 0, "R6");          // 03
    step(1, 8'h78, 0, 0, 0, "R6");          // C3, locks
    // R6: completion on the releasing read wins
    step(0, 0, 1, 10'h001, 0, "R6");
    step(1, 8'h79, 1, 10'h155, 0, "R6");
    step(1, 8'h78, 0, 0, 0, "R6");          // 55
    step(1, 8'h79, 0, 0, 0, "R6");          // 01
    // R10: completion with the low read is parked
    step(1, 8'h78, 1, 10'h2EE, 0, "R10");   // 55
    step(1, 8'h79, 0, 0, 0, "R10");         // 01
    step(1, 8'h78, 0, 0, 0, "R10");         // EE
    step(1, 8'h79, 0, 0, 0, "R10");         // 02
    // R9: unmapped and strobe-less
    step(1, 8'h7A, 0, 0, 0, "R9");
    step(1, 8'h77, 0, 0, 1, "R9");
    step(0, 8'h78, 0, 0, 0, "R9");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] pick = 3'($urandom_range(0, 7));
      logic [7:0] a = (pick < 3) ? 8'h78 : (pick < 6) ? 8'h79 : 8'($urandom);
      step(($urandom_range(0, 2) != 0), a, ($urandom_range(0, 2) == 0),
           10'($urandom), ($urandom_range(0, 5) == 0) ? ~align_left : align_left, "");
    end
    idle(0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule